// File: doc/BRIEF.md
# Switch Register Access Bridge

The bridge gives a host processor indirect access to the register file inside a network switch. The switch registers are addressed by an 8-bit page and an 8-bit register number and hold up to 64 bits each. The host uses a small 32-bit register window with address, write enable, read enable, write data and read data. Read data is combinational from the bridge state.

The host uses the bridge in four steps. First it raises a request bit in the control word and waits until the grant bit reads back as 1. Next it loads the two staging words, one for the upper 32 bits of the data and one for the lower 32 bits. It then writes a command word carrying page, register, direction and a go bit. Finally it polls until the go bit reads 0.

On the switch side there is one request/acknowledge port, and it never has more than one request outstanding. The acknowledge carries the read data, which the bridge captures in the same cycle that it clears the go bit. When software does 48-bit accesses it uses only the low 16 bits of the upper word. For 8, 16 and 32-bit accesses it uses only the lower word.

Top module: `swreg_bridge`

## Requirements
- R1: After reset the command word (0x2C), both read-result words (0x38, 0x3C) and the request/grant bits of the control word (0x40) all read 0, and `sw_req` is 0.
- R2: Writing 1 to control bit 3 (request) makes control bit 4 (grant) read 1 exactly GRANT_LAT clock edges after the write edge, and 0 before that. Writing 0 to bit 3 makes bit 4 read 0 right after that write edge.
- R3: Control bit 6 reads the level of `sw_init_done`, and writes cannot change it.
- R4: The staging words at 0x30 (upper) and 0x34 (lower) read back what was written, and `sw_wdata` carries {0x30, 0x34}.
- R5: A command write to 0x2C with bit 0 set, while the grant is held and no transaction is active, is accepted. Bits 31:24 are the page, bits 23:16 the register, bit 2 the reset flag and bit 1 the direction (1 = write, 0 = read). From the next cycle `sw_req`, `sw_page`, `sw_reg` and `sw_write` carry the command, and the command word reads back {page, reg, 13'b0, reset, dir, 1}.
- R6: `sw_req` stays high, with the same page, register and direction, until the cycle in which `sw_ack` is sampled high.
- R7: At the edge that samples `sw_ack`, the go bit clears. For a read, `sw_rdata[63:32]` is captured into 0x38 and `sw_rdata[31:0]` into 0x3C. For a write, both read-result words keep their values.
- R8: A command write while the grant is not held starts nothing, and the command word keeps its value.
- R9: A command write while a transaction is active is ignored. The port fields and the command word do not change, and no second request is issued.
- R10: Unmapped or unaligned offsets read 0. Writes to them, and writes to the read-result words, change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host byte offset |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_rd is high |
| sw_init_done | input | 1 | Switch has finished initialization |
| sw_req | output | 1 | Switch-side request |
| sw_write | output | 1 | Request direction, 1 = write |
| sw_page | output | 8 | Switch register page |
| sw_reg | output | 8 | Switch register number |
| sw_wdata | output | 64 | Write data for the switch |
| sw_ack | input | 1 | Switch acknowledge, one cycle |
| sw_rdata | input | 64 | Read data, valid with sw_ack |

## Verification
All host writes take effect at one clock edge, and host reads are combinational. The bench therefore drives inputs at the falling edge and samples at the next falling edge, which is the first point where a register result is due. For example, `sw_req` and the busy go bit are due one edge after the command write. The grant is due GRANT_LAT edges after the request write, so the bench samples it after each of those edges in turn. The cleared go bit and the captured read data are due one edge after `sw_ack`, so the bench checks them at the falling edge that follows the acknowledge. The bench sweeps many page/register pairs, both directions, and acknowledge delays of one to four cycles, and it computes the expected switch read data arithmetically from the page and register.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam int unsigned HOST_AW  = 8;
    localparam int unsigned HOST_DW  = 32;
    localparam int unsigned PAGE_W   = 8;
    localparam int unsigned REGN_W   = 8;
    localparam int unsigned SW_DW    = 2 * HOST_DW;

    localparam logic [HOST_AW-1:0] OFS_CMD = 8'h2C;
    localparam logic [HOST_AW-1:0] OFS_WHI = 8'h30;
    localparam logic [HOST_AW-1:0] OFS_WLO = 8'h34;
    localparam logic [HOST_AW-1:0] OFS_RHI = 8'h38;
    localparam logic [HOST_AW-1:0] OFS_RLO = 8'h3C;
    localparam logic [HOST_AW-1:0] OFS_CTL = 8'h40;

    localparam int unsigned CMD_GO    = 0;
    localparam int unsigned CMD_DIR   = 1;
    localparam int unsigned CMD_RST   = 2;
    localparam int unsigned CMD_REG0  = 16;
    localparam int unsigned CMD_PAGE0 = 24;
    localparam int unsigned CTL_REQ   = 3;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [REGN_W-1:0] regn;
        logic              rst;
        logic              dir;
    } cmd_t;
endpackage

// File: rtl/swb_grant.sv
module swb_grant #(
    parameter int unsigned LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic gnt_o
);
    localparam int unsigned CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          gnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!req_i) begin
            st_d.cnt = '0;
            st_d.gnt = 1'b0;
        end else if (!st_q.gnt) begin
            if (st_q.cnt == CW'(LAT - 1)) st_d.gnt = 1'b1;
            else                          st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_o = st_q.gnt & req_i;

    // R2: a cleared request leaves no stored grant behind
    a_r2_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !st_q.gnt);
    // R2: a held grant persists while the request stays up
    a_r2_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o |=> (gnt_o || !req_i));
endmodule

// File: rtl/swb_xact.sv
module swb_xact
    import swb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  cmd_t             cmd_i,
    input  logic             sw_ack_i,
    input  logic [SW_DW-1:0] sw_rdata_i,
    output logic             busy_o,
    output cmd_t             cmd_o,
    output logic [SW_DW-1:0] rdata_o
);
    typedef struct packed {
        logic             busy;
        cmd_t             cmd;
        logic [SW_DW-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cmd  = cmd_i;
            end
        end else if (sw_ack_i) begin
            st_d.busy = 1'b0;
            if (!st_q.cmd.dir) st_d.rdata = sw_rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign cmd_o   = st_q.cmd;
    assign rdata_o = st_q.rdata;

    // R6: the request persists until acknowledged
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sw_ack_i) |=> busy_o);
    // R7: an acknowledge always clears the go flag
    a_r7_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sw_ack_i) |=> !busy_o);
    // R7: read results only move on an acknowledge
    a_r7_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(rdata_o));
    // R7: a write transaction leaves read results alone
    a_r7_write_keeps_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_o.dir) |=> $stable(rdata_o));
    // R9: command fields frozen while a transaction is active
    a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cmd_o));
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
    import swb_pkg::*;
#(
    parameter int unsigned GRANT_LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               sw_init_done,
    output logic               sw_req,
    output logic               sw_write,
    output logic [PAGE_W-1:0]  sw_page,
    output logic [REGN_W-1:0]  sw_reg,
    output logic [SW_DW-1:0]   sw_wdata,
    input  logic               sw_ack,
    input  logic [SW_DW-1:0]   sw_rdata
);
    localparam int unsigned PAD_W = CMD_REG0 - CMD_RST - 1;

    typedef struct packed {
        logic               req;
        logic [HOST_DW-1:0] whi;
        logic [HOST_DW-1:0] wlo;
    } st_t;

    st_t st_d, st_q;

    logic             gnt;
    logic             busy;
    logic             start;
    cmd_t             new_cmd;
    cmd_t             cur_cmd;
    logic [SW_DW-1:0] rdata;

    always_comb begin
        st_d = st_q;
        if (host_wr) begin
            unique case (host_addr)
                OFS_CTL: st_d.req = host_wdata[CTL_REQ];
                OFS_WHI: st_d.whi = host_wdata;
                OFS_WLO: st_d.wlo = host_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = host_wr && (host_addr == OFS_CMD) && host_wdata[CMD_GO] && gnt;

    always_comb begin
        new_cmd.page = host_wdata[CMD_PAGE0 +: PAGE_W];
        new_cmd.regn = host_wdata[CMD_REG0 +: REGN_W];
        new_cmd.rst  = host_wdata[CMD_RST];
        new_cmd.dir  = host_wdata[CMD_DIR];
    end

    swb_grant #(.LAT(GRANT_LAT)) grant_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (st_q.req),
        .gnt_o (gnt)
    );

    swb_xact xact_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmd_i      (new_cmd),
        .sw_ack_i   (sw_ack),
        .sw_rdata_i (sw_rdata),
        .busy_o     (busy),
        .cmd_o      (cur_cmd),
        .rdata_o    (rdata)
    );

    assign sw_req   = busy;
    assign sw_write = cur_cmd.dir;
    assign sw_page  = cur_cmd.page;
    assign sw_reg   = cur_cmd.regn;
    assign sw_wdata = {st_q.whi, st_q.wlo};

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (host_addr)
                OFS_CMD: host_rdata = {cur_cmd.page, cur_cmd.regn, {PAD_W{1'b0}},
                                       cur_cmd.rst, cur_cmd.dir, busy};
                OFS_WHI: host_rdata = st_q.whi;
                OFS_WLO: host_rdata = st_q.wlo;
                OFS_RHI: host_rdata = rdata[SW_DW-1 -: HOST_DW];
                OFS_RLO: host_rdata = rdata[HOST_DW-1:0];
                OFS_CTL: host_rdata = {25'b0, sw_init_done, 1'b0, gnt, st_q.req, 3'b0};
                default: host_rdata = '0;
            endcase
        end
    end

    // R8: a transaction only starts from an edge where the grant was held
    a_r8_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gnt));
    // R2: the grant never appears in the cycle the request rises
    a_r2_no_instant_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> !gnt);
    // R4: staging words move only on host writes
    a_r4_stage_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(sw_wdata));
endmodule

// File: tb/swreg_bridge_tb_top.sv
module swreg_bridge_tb_top;
    localparam int unsigned LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sw_init_done = 1'b0;
    logic        sw_req, sw_write;
    logic [7:0]  sw_page, sw_reg;
    logic [63:0] sw_wdata;
    logic        sw_ack = 1'b0;
    logic [63:0] sw_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    swreg_bridge #(.GRANT_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sw_init_done(sw_init_done), .sw_req(sw_req), .sw_write(sw_write),
        .sw_page(sw_page), .sw_reg(sw_reg), .sw_wdata(sw_wdata),
        .sw_ack(sw_ack), .sw_rdata(sw_rdata)
    );

    function automatic logic [63:0] model(input logic [7:0] p, input logic [7:0] r);
        return {p, r, p ^ 8'hA5, r + 8'd3, ~p, ~r, p + r, 8'h5A};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    logic [31:0] v;
    logic [63:0] exp_rd = '0;
    logic [31:0] exp_cmd = '0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        hread(8'h2C, v); chk("R1 cmd", 64'(v), 64'h0);
        hread(8'h38, v); chk("R1 rhi", 64'(v), 64'h0);
        hread(8'h3C, v); chk("R1 rlo", 64'(v), 64'h0);
        hread(8'h40, v); chk("R1 ctl", 64'(v), 64'h0);
        chk("R1 sw_req", 64'(sw_req), 64'h0);
        // R3 init flag
        sw_init_done = 1'b1;
        hread(8'h40, v); chk("R3 init", 64'(v), 64'h40);
        // R8 command without grant
        hwrite(8'h2C, 32'h1234_0003);
        chk("R8 no req", 64'(sw_req), 64'h0);
        hread(8'h2C, v); chk("R8 cmd kept", 64'(v), 64'h0);
        // R2 grant latency
        hwrite(8'h40, 32'h0000_0008);
        for (int k = 0; k <= int'(LAT); k++) begin
            hread(8'h40, v);
            chk("R2 grant timing", 64'(v), (k >= int'(LAT)) ? 64'h58 : 64'h48);
            @(negedge clk);
        end
        hwrite(8'h40, 32'hFFFF_FFB8);
        hread(8'h40, v); chk("R3 init read-only", 64'(v), 64'h58);
        // R4 staging
        hwrite(8'h30, 32'hDEAD_BEEF);
        hwrite(8'h34, 32'h0123_4567);
        hread(8'h30, v); chk("R4 whi", 64'(v), 64'hDEAD_BEEF);
        hread(8'h34, v); chk("R4 wlo", 64'(v), 64'h0123_4567);
        chk("R4 sw_wdata", sw_wdata, 64'hDEAD_BEEF_0123_4567);
        // sweep of transactions
        for (int i = 0; i < 24; i++) begin
            logic [7:0] p, r;
            logic dir, rs;
            int dly;
            logic [63:0] wd;
            p = 8'(i * 37 + 5);
            r = 8'(i * 53 + 11);
            dir = (i % 3 == 0);
            rs = i[0];
            dly = i % 4 + 1;
            wd = {p, ~r, r, p ^ r, 8'(i), 8'hC3, ~p, r};
            if (dir) begin
                hwrite(8'h30, wd[63:32]);
                hwrite(8'h34, wd[31:0]);
            end
            hwrite(8'h2C, {p, r, 13'b0, rs, dir, 1'b1});
            exp_cmd = {p, r, 13'b0, rs, dir, 1'b0};
            chk("R5 sw_req", 64'(sw_req), 64'h1);
            chk("R5 page", 64'(sw_page), 64'(p));
            chk("R5 reg", 64'(sw_reg), 64'(r));
            chk("R5 dir", 64'(sw_write), 64'(dir));
            if (dir) chk("R4 write data", sw_wdata, wd);
            hread(8'h2C, v); chk("R5 cmd busy", 64'(v), 64'(exp_cmd | 32'h1));
            if (i == 5) begin
                // R9 command while busy
                hwrite(8'h2C, 32'hABCD_0007);
                chk("R9 page kept", 64'(sw_page), 64'(p));
                chk("R9 reg kept", 64'(sw_reg), 64'(r));
                hread(8'h2C, v); chk("R9 cmd kept", 64'(v), 64'(exp_cmd | 32'h1));
            end
            for (int w = 0; w < dly; w++) begin
                @(negedge clk);
                chk("R6 req held", {sw_req, sw_write, sw_page, sw_reg},
                    {1'b1, dir, p, r});
            end
            sw_ack = 1'b1; sw_rdata = model(p, r);
            @(negedge clk);
            sw_ack = 1'b0; sw_rdata = '0;
            if (!dir) exp_rd = model(p, r);
            chk("R7 req drop", 64'(sw_req), 64'h0);
            hread(8'h2C, v); chk("R7 go clear", 64'(v), 64'(exp_cmd));
            hread(8'h38, v); chk("R7 rhi", 64'(v), 64'(exp_rd[63:32]));
            hread(8'h3C, v); chk("R7 rlo", 64'(v), 64'(exp_rd[31:0]));
            @(negedge clk);
            chk("R9 single request", 64'(sw_req), 64'h0);
        end
        // R10 unmapped offsets and read-only result words
        hread(8'h00, v); chk("R10 off00", 64'(v), 64'h0);
        hread(8'h2D, v); chk("R10 unaligned", 64'(v), 64'h0);
        hwrite(8'h44, 32'hFFFF_FFFF);
        hread(8'h44, v); chk("R10 off44", 64'(v), 64'h0);
        hwrite(8'h38, 32'h1111_1111);
        hwrite(8'h3C, 32'h2222_2222);
        hread(8'h38, v); chk("R10 rhi ro", 64'(v), 64'(exp_rd[63:32]));
        hread(8'h3C, v); chk("R10 rlo ro", 64'(v), 64'(exp_rd[31:0]));
        hread(8'h2C, v); chk("R10 cmd intact", 64'(v), 64'(exp_cmd));
        // R2 release, then R8 command after release
        hwrite(8'h40, 32'h0);
        hread(8'h40, v); chk("R2 release", 64'(v), 64'h40);
        hwrite(8'h2C, 32'h7777_0001);
        chk("R8 no req after release", 64'(sw_req), 64'h0);
        hread(8'h2C, v); chk("R8 cmd kept after release", 64'(v), 64'(exp_cmd));
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule